// File: doc/BRIEF.md
# Three-Wire Serial Register Write Port

This block is a write-only serial slave with three inputs: an active-low chip-select, a serial clock and a serial data line. It fills an internal bank of 64 eight-bit control registers. A host lowers chip-select and shifts in one 16-bit frame, most significant bit first. The frame holds a two-bit header that must be "1" then "0", then a six-bit register index, then an eight-bit value. The host then raises chip-select. The write takes effect only on that rising edge, and only when the frame is well formed.

The three serial inputs are asynchronous to the system clock. Each passes through a two-flop synchronizer, and the serial clock and chip-select edges are detected in the system clock domain. For that reason the system clock must run at least four times faster than the serial clock. The whole bank is presented as one flat parallel output, so the logic next to the block can decode its own fields. A one-cycle strobe, together with the index and value just written, reports each accepted write.

Top module: `serwr_port`

## Requirements
- R1: A valid frame is 16 bits sent most significant bit first. It holds header bits [15:14] = 2'b10, register index bits [13:8] and value bits [7:0]. After a valid commit, entry k of the bank (`bank_o[8k+7:8k]`) holds the value sent with index k.
- R2: A data bit is captured only on a serial-clock rising edge seen while chip-select is low. Serial-clock edges while chip-select is high do not change the frame that follows.
- R3: A chip-select falling edge starts a new frame and clears the bit count. A partly sent frame that is not followed by a rising chip-select has no effect.
- R4: The write is committed only on the chip-select rising edge. After the sixteenth serial-clock edge, and before chip-select rises, the bank and the strobe stay unchanged.
- R5: A frame whose header is not 2'b10 is dropped, and no register changes.
- R6: A frame that ends with fewer than 16 bits is dropped, and no register changes.
- R7: A frame with more than 16 serial-clock edges before chip-select rises is dropped, and no register changes.
- R8: After a valid commit, `wr_stb_o` is high for exactly one cycle, and `wr_idx_o` and `wr_val_o` carry the written index and value. The bank shows the new value in that same cycle. The bank never changes in a cycle without the strobe.
- R9: While `rst_ni` is low, all 64 registers read zero and `wr_stb_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_cs_ni | input | 1 | Serial chip-select, active low |
| ser_clk_i | input | 1 | Serial clock, data captured on its rising edge |
| ser_dat_i | input | 1 | Serial data, most significant bit first |
| bank_o | output | 512 | All 64 registers, entry k at bits [8k+7:8k] |
| wr_stb_o | output | 1 | One-cycle pulse after each committed write |
| wr_idx_o | output | 6 | Register index of the last committed write |
| wr_val_o | output | 8 | Value of the last committed write |

## Verification
Valid frames are sent with distinct index and value patterns: the lowest and highest index, alternating bit patterns, and a rewrite of the same index. These show that the header, index and value fields are split at the right bit positions. Malformed frames are interleaved with the valid ones: a wrong header, 15 bits, 17 bits, and a frame abandoned by a new chip-select fall. Each one is followed by a full comparison of the bank, which separates the count check, the overflow check and the header check from one another. A hold with chip-select low after the sixteenth bit shows that the commit waits for the rising edge and not for the bit count. Serial-clock toggling while chip-select is high shows that bits are captured only inside a frame.

// File: rtl/ser_wr_pkg.sv
package ser_wr_pkg;
  localparam int unsigned HDR_W = 2;
  localparam logic [HDR_W-1:0] HDR_PATTERN = 2'b10;
endpackage

// File: rtl/ser_rst_sync.sv
module ser_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/ser_sync.sv
module ser_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = async_i;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else         stage_q[s] <= stage_d;
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/ser_frame_rx.sv
module ser_frame_rx
  import ser_wr_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              sdat_i,
  output logic              commit_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned FRAME_LEN = HDR_W + ADDR_W + DATA_W;
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_LEN);

  logic                 cs_prev_q, sclk_prev_q;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 ovf_q, ovf_d;
  logic [FRAME_LEN-1:0] shreg_q, shreg_d;
  logic                 shreg_en;
  logic                 cs_fall, cs_rise, bit_take;

  assign cs_fall  = !cs_n_i && cs_prev_q;
  assign cs_rise  = cs_n_i && !cs_prev_q;
  assign bit_take = !cs_n_i && sclk_i && !sclk_prev_q;

  // next-state logic
  always_comb begin
    cnt_d    = cnt_q;
    ovf_d    = ovf_q;
    shreg_d  = shreg_q;
    shreg_en = 1'b0;
    if (cs_fall) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (bit_take) begin
      if (cnt_q == CNT_FULL) begin
        ovf_d = 1'b1;
      end else begin
        cnt_d    = cnt_q + 1'b1;
        shreg_d  = {shreg_q[FRAME_LEN-2:0], sdat_i};
        shreg_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b0;
      cnt_q       <= '0;
      ovf_q       <= 1'b0;
    end else begin
      cs_prev_q   <= cs_n_i;
      sclk_prev_q <= sclk_i;
      cnt_q       <= cnt_d;
      ovf_q       <= ovf_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       shreg_q <= '0;
    else if (shreg_en) shreg_q <= shreg_d;
  end

  assign commit_o = cs_rise && (cnt_q == CNT_FULL) && !ovf_q &&
                    (shreg_q[FRAME_LEN-1 -: HDR_W] == HDR_PATTERN);
  assign addr_o   = shreg_q[DATA_W +: ADDR_W];
  assign data_o   = shreg_q[DATA_W-1:0];
endmodule

// File: rtl/ser_reg_bank.sv
module ser_reg_bank #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                data_i,
  output logic [(1<<ADDR_W)*DATA_W-1:0]    bank_o,
  output logic                             stb_o,
  output logic [ADDR_W-1:0]                stb_addr_o,
  output logic [DATA_W-1:0]                stb_data_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    logic              hit;
    logic [DATA_W-1:0] q;
    assign hit = we_i && (addr_i == ADDR_W'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= '0;
      else if (hit) q <= data_i;
    end
    assign bank_o[k*DATA_W +: DATA_W] = q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stb_o <= 1'b0;
    else         stb_o <= we_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_addr_o <= '0;
      stb_data_o <= '0;
    end else if (we_i) begin
      stb_addr_o <= addr_i;
      stb_data_o <= data_i;
    end
  end
endmodule

// File: rtl/serwr_port.sv
module serwr_port #(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          ser_cs_ni,
  input  logic                          ser_clk_i,
  input  logic                          ser_dat_i,
  output logic [(1<<ADDR_W)*DATA_W-1:0] bank_o,
  output logic                          wr_stb_o,
  output logic [ADDR_W-1:0]             wr_idx_o,
  output logic [DATA_W-1:0]             wr_val_o
);
  logic              rst_n_int;
  logic [2:0]        pins_sync;
  logic              cs_n_sync, sclk_sync, sdat_sync;
  logic              commit;
  logic [ADDR_W-1:0] rx_addr;
  logic [DATA_W-1:0] rx_data;

  ser_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_n_int)
  );

  ser_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_n_int),
    .async_i({ser_cs_ni, ser_clk_i, ser_dat_i}), .sync_o(pins_sync)
  );
  assign {cs_n_sync, sclk_sync, sdat_sync} = pins_sync;

  ser_frame_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_n_int),
    .cs_n_i(cs_n_sync), .sclk_i(sclk_sync), .sdat_i(sdat_sync),
    .commit_o(commit), .addr_o(rx_addr), .data_o(rx_data)
  );

  ser_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_n_int),
    .we_i(commit), .addr_i(rx_addr), .data_i(rx_data),
    .bank_o(bank_o), .stb_o(wr_stb_o),
    .stb_addr_o(wr_idx_o), .stb_data_o(wr_val_o)
  );
endmodule

// File: rtl/serwr_port_chk.sv
module serwr_port_chk #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cs_n_sync,
  input logic [(1<<ADDR_W)*DATA_W-1:0] bank,
  input logic                          stb,
  input logic [ADDR_W-1:0]             idx,
  input logic [DATA_W-1:0]             val
);
  // R8: strobe lasts a single cycle
  assert_stb_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);

  // R8: strobe reports what the bank now holds
  assert_stb_matches_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> bank[int'(idx)*DATA_W +: DATA_W] == val);

  // R5 R6 R7: no register change without a reported write
  assert_bank_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |-> $stable(bank));

  // R4: a write is only reported once chip-select has risen
  assert_commit_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> cs_n_sync);
endmodule

bind serwr_port serwr_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk_i), .rst_n(rst_ni), .cs_n_sync(cs_n_sync), .bank(bank_o),
  .stb(wr_stb_o), .idx(wr_idx_o), .val(wr_val_o)
);

// File: tb/sim_serwr_port.sv
`timescale 1ns/1ps
module sim_serwr_port;
  localparam int HALF = 4;  // system cycles per serial half period

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [511:0] bank;
  logic         stb;
  logic [5:0]   idx;
  logic [7:0]   val;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  logic [13:0]  exp_q[$];
  logic [511:0] model = '0;

  always #2.5 clk = ~clk;

  serwr_port u0 (
    .clk_i(clk), .rst_ni(rst_n), .ser_cs_ni(cs_n), .ser_clk_i(sck),
    .ser_dat_i(sdi), .bank_o(bank), .wr_stb_o(stb), .wr_idx_o(idx),
    .wr_val_o(val)
  );

  task automatic check(input string tag, input logic [511:0] act,
                       input logic [511:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && stb) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R8 unexpected strobe act=%h/%h exp=none", idx, val);
      end else begin
        logic [13:0] e;
        e = exp_q.pop_front();
        if ({idx, val} !== e || bank[idx*8 +: 8] !== val) begin
          n_fail++;
          $display("FAIL R8 strobe act=%h/%h bank=%h exp=%h/%h",
                   idx, val, bank[idx*8 +: 8], e[13:8], e[7:0]);
        end
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] pat, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = pat[i];
      wait_cyc(HALF);
      sck = 1'b1;
      wait_cyc(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic open_frame();
    cs_n = 1'b0;
    wait_cyc(HALF);
  endtask

  task automatic close_frame();
    wait_cyc(HALF);
    cs_n = 1'b1;
    wait_cyc(12);
  endtask

  // valid write: push expectation, update model
  task automatic good_write(input logic [5:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
    model[a*8 +: 8] = d;
    open_frame();
    shift_bits({16'h0, 2'b10, a, d}, 16);
    close_frame();
  endtask

  initial begin
    wait_cyc(3);
    // R9: reset state
    check("R9 bank in reset", bank, '0);
    check("R9 strobe in reset", {511'b0, stb}, '0);
    rst_n = 1'b1;
    wait_cyc(6);

    // R1: several patterns
    good_write(6'h00, 8'hA5);
    check("R1 index 0", bank, model);
    good_write(6'h3F, 8'h5A);
    check("R1 index 63", bank, model);
    good_write(6'h15, 8'hFF);
    good_write(6'h2A, 8'h01);
    check("R1 mixed", bank, model);
    good_write(6'h15, 8'h80);
    check("R1 rewrite", bank, model);

    // R5: bad headers
    open_frame(); shift_bits({16'h0, 2'b11, 6'h07, 8'h33}, 16); close_frame();
    check("R5 header 11", bank, model);
    open_frame(); shift_bits({16'h0, 2'b00, 6'h07, 8'h33}, 16); close_frame();
    check("R5 header 00", bank, model);
    open_frame(); shift_bits({16'h0, 2'b01, 6'h07, 8'h33}, 16); close_frame();
    check("R5 header 01", bank, model);

    // R6: short frame (15 bits)
    open_frame(); shift_bits({17'h0, 2'b10, 6'h08, 7'h11}, 15); close_frame();
    check("R6 15 bits", bank, model);

    // R7: 17 bits
    open_frame(); shift_bits({15'h0, 2'b10, 6'h09, 8'h44, 1'b1}, 17); close_frame();
    check("R7 17 bits", bank, model);

    // R4: hold cs low after 16th bit
    exp_q.push_back({6'h0B, 8'hC3});
    open_frame();
    shift_bits({16'h0, 2'b10, 6'h0B, 8'hC3}, 16);
    wait_cyc(20);
    check("R4 no write before rise", bank, model);
    check("R4 queue still pending", {480'b0, 32'(exp_q.size())}, 512'd1);
    model[8'h0B*8 +: 8] = 8'hC3;
    close_frame();
    check("R4 write on rise", bank, model);

    // R3: abandoned partial frame, then new frame via cs fall
    open_frame(); shift_bits({16'h0, 2'b10, 6'h0C, 8'h99}, 10);
    cs_n = 1'b1; wait_cyc(2);
    exp_q.push_back({6'h0D, 8'h6E});
    model[8'h0D*8 +: 8] = 8'h6E;
    cs_n = 1'b0; wait_cyc(HALF);
    shift_bits({16'h0, 2'b10, 6'h0D, 8'h6E}, 16);
    close_frame();
    check("R3 restart after fall", bank, model);

    // R2: serial clock edges with cs high are ignored
    shift_bits({24'h0, 8'hFF}, 8);
    check("R2 idle clocks no write", bank, model);
    good_write(6'h10, 8'h3C);
    check("R2 frame after idle clocks", bank, model);

    wait_cyc(10);
    check("R8 all strobes seen", {480'b0, 32'(exp_q.size())}, '0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule